// File: doc/BRIEF.md
# Branch and Call Next-PC Unit

This block is the instruction sequencer of a 32-bit processor whose instructions are each one word long. It holds the program counter, looks at the control-transfer fields of the instruction word presented to it, and picks the address of the next instruction. The choices are the next word in line, a PC-relative conditional branch, a PC-relative call, and a register-indirect jump-and-link. Conditional branches are resolved against the four condition flags (negative, zero, overflow, carry) supplied by the rest of the core.

For calls and jump-and-link the block also issues a write request toward the register file: a register index and the value to store, which is always the address of the transfer instruction itself. The register file read values needed by jump-and-link arrive on two operand inputs. The program counter advances once per clock in which `stepEn` is high and otherwise holds.

Top module: `pcSequencer`

## Requirements
- R1: After reset `pcOut` equals 2048 (0x0000_0800) and `linkWe` is low while `stepEn` is low.
- R2: A stepped instruction that is not a transfer (format bits 31..30 = 11, format 10 with bits 24..19 other than 111000, or format 00 with bits 24..22 other than 010) moves `pcOut` to `pcOut + 4` at the next clock edge.
- R3: A stepped branch (bits 31..30 = 00, bits 24..22 = 010) with condition bits 28..25 = 0001 tests z, 0101 tests c, 0110 tests n, 0111 tests v and 1000 is unconditional; when taken the next PC is the branch address plus four times bits 21..0 sign-extended, otherwise the branch address plus 4.
- R4: A branch whose condition field holds any other code never takes, whatever the flags.
- R5: A stepped call (bits 31..30 = 01) sets the next PC to its own address plus four times bits 29..0, modulo 2^32, and requests a write of its own address into register 15.
- R6: A stepped jump-and-link (bits 31..30 = 10, bits 24..19 = 111000) sets the next PC to `srcA` plus the second operand, which is the sign-extended bits 12..0 when bit 13 is 1 and `srcB` when bit 13 is 0; it requests a write of its own address into the register named by bits 29..25.
- R7: A link write whose target register is 0 is suppressed (`linkWe` low), while the jump itself still happens.
- R8: `linkWe` is high only for a stepped call or jump-and-link.
- R9: While `stepEn` is low the PC holds and `linkWe` stays low, whatever the instruction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Current instruction word is valid; advance the PC this cycle |
| instrWord | input | 32 | Instruction at address `pcOut` |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| srcA | input | 32 | Value of the first source register |
| srcB | input | 32 | Value of the second source register |
| pcOut | output | 32 | Current program counter |
| linkWe | output | 1 | Link write request |
| linkReg | output | 5 | Register index of the link write |
| linkData | output | 32 | Value of the link write (address of the transfer) |

## Verification
Each of the four flag-tested conditions is run once with only its own flag set and once with every other flag set, so a condition wired to the wrong flag or with inverted sense shows up as a wrong PC. Unlisted condition codes are run with all flags set to separate never-taken from taken. Forward and backward displacements and a call that crosses the top of the address space tell sign handling and wrap-around apart, while jump-and-link is tried with a register operand, a negative immediate and a zero destination, and a transfer word held with `stepEn` low shows that nothing moves without a step.

// File: rtl/pcSeqPkg.sv
package pcSeqPkg;

  localparam int XLEN      = 32;
  localparam int REGW      = 5;
  localparam int CONDW     = 4;
  localparam int BR_DISPW  = 22;
  localparam int CALL_DISPW = 30;
  localparam int IMMW      = 13;

  localparam logic [1:0] FMT_XFER = 2'b00;
  localparam logic [1:0] FMT_CALL = 2'b01;
  localparam logic [1:0] FMT_ALU  = 2'b10;
  localparam logic [2:0] SUB_BRANCH = 3'b010;
  localparam logic [5:0] ALU_JMPL = 6'b111000;
  localparam logic [REGW-1:0] CALL_LINK_REG = 5'd15;

  typedef enum logic [1:0] {
    TGT_SEQ   = 2'd0,
    TGT_REL22 = 2'd1,
    TGT_REL30 = 2'd2,
    TGT_REG   = 2'd3
  } tgtSel_e;

  typedef struct packed {
    logic            advance;
    tgtSel_e         tgtSel;
    logic            linkEn;
    logic [REGW-1:0] linkIdx;
  } seqStrobe_t;

  function automatic logic condMet(input logic [CONDW-1:0] cond,
                                   input logic n, input logic z,
                                   input logic v, input logic c);
    case (cond)
      4'b0001: condMet = z;
      4'b0101: condMet = c;
      4'b0110: condMet = n;
      4'b0111: condMet = v;
      4'b1000: condMet = 1'b1;
      default: condMet = 1'b0;
    endcase
  endfunction

  function automatic logic condListed(input logic [CONDW-1:0] cond);
    condListed = (cond == 4'b0001) || (cond == 4'b0101) || (cond == 4'b0110) ||
                 (cond == 4'b0111) || (cond == 4'b1000);
  endfunction

endpackage

// File: rtl/pcSeqCtrl.sv
module pcSeqCtrl
  import pcSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [XLEN-1:0]   instrWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic              flagC,
  output seqStrobe_t        strobe
);

  logic [1:0]       fmt;
  logic [2:0]       subOp;
  logic [5:0]       aluOp;
  logic [CONDW-1:0] cond;
  logic [REGW-1:0]  rdIdx;
  logic             isBranch;
  logic             isCall;
  logic             isJmpl;
  logic             taken;

  assign fmt   = instrWord[31:30];
  assign subOp = instrWord[24:22];
  assign aluOp = instrWord[24:19];
  assign cond  = instrWord[28:25];
  assign rdIdx = instrWord[29:25];

  assign isBranch = (fmt == FMT_XFER) && (subOp == SUB_BRANCH);
  assign isCall   = (fmt == FMT_CALL);
  assign isJmpl   = (fmt == FMT_ALU) && (aluOp == ALU_JMPL);
  assign taken    = condMet(cond, flagN, flagZ, flagV, flagC);

  always_comb begin
    strobe.advance = stepEn;
    strobe.tgtSel  = TGT_SEQ;
    strobe.linkEn  = 1'b0;
    strobe.linkIdx = '0;
    if (isBranch && taken) begin
      strobe.tgtSel = TGT_REL22;
    end else if (isCall) begin
      strobe.tgtSel  = TGT_REL30;
      strobe.linkIdx = CALL_LINK_REG;
      strobe.linkEn  = stepEn;
    end else if (isJmpl) begin
      strobe.tgtSel  = TGT_REG;
      strobe.linkIdx = rdIdx;
      strobe.linkEn  = stepEn && (rdIdx != '0);
    end
  end

  AST_CALL_LINKS_15: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && fmt == FMT_CALL) |-> (strobe.linkEn && strobe.linkIdx == CALL_LINK_REG)); // R5

  AST_NO_ZERO_LINK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkEn |-> (strobe.linkIdx != '0)); // R7

  AST_LINK_ONLY_XFER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkEn |-> (stepEn && (fmt == FMT_CALL || (fmt == FMT_ALU && aluOp == ALU_JMPL)))); // R8

  AST_UNLISTED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (fmt == FMT_XFER && subOp == SUB_BRANCH && !condListed(cond)) |-> (strobe.tgtSel == TGT_SEQ)); // R4

endmodule

// File: rtl/pcSeqPath.sv
module pcSeqPath
  import pcSeqPkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'd2048
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [XLEN-1:0] instrWord,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] linkData
);

  localparam int BR_PAD   = XLEN - BR_DISPW - 2;
  localparam int CALL_PAD = XLEN - CALL_DISPW - 2;
  localparam int IMM_PAD  = XLEN - IMMW;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] nextPc;
  logic [XLEN-1:0] brOffset;
  logic [XLEN-1:0] callOffset;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] seqPc;

  assign brOffset   = {{BR_PAD{instrWord[BR_DISPW-1]}}, instrWord[BR_DISPW-1:0], 2'b00};
  assign immExt     = {{IMM_PAD{instrWord[IMMW-1]}}, instrWord[IMMW-1:0]};
  assign opB        = instrWord[IMMW] ? immExt : srcB;
  assign seqPc      = pc + 32'd4;

  generate
    if (CALL_PAD > 0) begin : g_callPad
      assign callOffset = {{CALL_PAD{1'b0}}, instrWord[CALL_DISPW-1:0], 2'b00};
    end else begin : g_callNoPad
      assign callOffset = {instrWord[CALL_DISPW-1:0], 2'b00};
    end
  endgenerate

  always_comb begin
    case (strobe.tgtSel)
      TGT_REL22: nextPc = pc + brOffset;
      TGT_REL30: nextPc = pc + callOffset;
      TGT_REG:   nextPc = srcA + opB;
      default:   nextPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= RESET_PC;
    end else if (strobe.advance) begin
      pc <= nextPc;
    end
  end

  assign pcOut    = pc;
  assign linkData = pc;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> (pcOut == $past(pcOut))); // R9

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.tgtSel == TGT_SEQ) |=> (pcOut == $past(pcOut) + 32'd4)); // R2

endmodule

// File: rtl/pcSequencer.sv
module pcSequencer
  import pcSeqPkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'd2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepEn,
  input  logic [31:0] instrWord,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagV,
  input  logic        flagC,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic [31:0] pcOut,
  output logic        linkWe,
  output logic [4:0]  linkReg,
  output logic [31:0] linkData
);

  seqStrobe_t strobe;

  pcSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .instrWord (instrWord),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagV     (flagV),
    .flagC     (flagC),
    .strobe    (strobe)
  );

  pcSeqPath #(.RESET_PC(RESET_PC)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrWord (instrWord),
    .srcA      (srcA),
    .srcB      (srcB),
    .pcOut     (pcOut),
    .linkData  (linkData)
  );

  assign linkWe  = strobe.linkEn;
  assign linkReg = strobe.linkIdx;

endmodule

// File: tb/pcSequencer_bench.sv
module pcSequencer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] instrWord = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [31:0] pcOut;
  logic        linkWe;
  logic [4:0]  linkReg;
  logic [31:0] linkData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] pc;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] modelPc;

  always #10 clk = ~clk;   // 50 MHz

  pcSequencer u_pcSequencer (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .instrWord(instrWord),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .srcA(srcA), .srcB(srcB), .pcOut(pcOut),
    .linkWe(linkWe), .linkReg(linkReg), .linkData(linkData)
  );

  function automatic logic [31:0] encBr(input logic [3:0] cond, input logic [21:0] disp);
    encBr = {2'b00, 1'b0, cond, 3'b010, disp};
  endfunction
  function automatic logic [31:0] encCall(input logic [29:0] disp);
    encCall = {2'b01, disp};
  endfunction
  function automatic logic [31:0] encJmpl(input logic [4:0] rd, input logic useImm,
                                          input logic [12:0] low);
    encJmpl = {2'b10, rd, 6'b111000, 5'd3, useImm, low};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one instruction at the falling edge, checks the link
  // request (combinational), and queues the expected PC after the edge.
  task automatic issue(input logic [31:0] w, input logic [3:0] nzvc,
                       input logic [31:0] a, input logic [31:0] b,
                       input bit en, input string tag);
    logic [31:0] nxt;
    logic        expWe;
    logic [4:0]  expReg;
    logic        tk;
    @(negedge clk);
    instrWord = w; {flagN, flagZ, flagV, flagC} = nzvc;
    srcA = a; srcB = b; stepEn = en;
    nxt = modelPc + 32'd4; expWe = 1'b0; expReg = '0;
    case (w[31:30])
      2'b00: if (w[24:22] == 3'b010) begin
        case (w[28:25])
          4'b0001: tk = nzvc[2];
          4'b0101: tk = nzvc[0];
          4'b0110: tk = nzvc[3];
          4'b0111: tk = nzvc[1];
          4'b1000: tk = 1'b1;
          default: tk = 1'b0;
        endcase
        if (tk) nxt = modelPc + {{8{w[21]}}, w[21:0], 2'b00};
      end
      2'b01: begin
        nxt = modelPc + {w[29:0], 2'b00}; expWe = 1'b1; expReg = 5'd15;
      end
      2'b10: if (w[24:19] == 6'b111000) begin
        nxt = a + (w[13] ? {{19{w[12]}}, w[12:0]} : b);
        expReg = w[29:25]; expWe = (expReg != 0);
      end
      default: ;
    endcase
    if (!en) begin nxt = modelPc; expWe = 1'b0; end
    #1;
    check(linkWe == expWe, {tag, " linkWe"}, {31'd0, linkWe}, {31'd0, expWe});
    if (expWe) begin
      check(linkReg == expReg, {tag, " linkReg"}, {27'd0, linkReg}, {27'd0, expReg});
      check(linkData == modelPc, {tag, " linkData"}, linkData, modelPc);
    end
    expQ.push_back('{nxt, tag});
    modelPc = nxt;
  endtask

  // Monitor: shortly after each rising edge, compare the PC with the queue.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(pcOut == it.pc, {it.tag, " pc"}, pcOut, it.pc);
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelPc = 32'd2048;
    repeat (3) @(negedge clk);
    check(pcOut == 32'd2048, "R1 reset pc", pcOut, 32'd2048);
    check(linkWe == 1'b0, "R1 reset linkWe", {31'd0, linkWe}, 32'd0);
    rstN = 1'b1;

    // R2 non-transfer instructions
    issue({2'b00, 5'd4, 3'b100, 22'h3ffff}, 4'hF, 0, 0, 1, "R2 upper-imm");
    issue({2'b10, 5'd3, 6'b010000, 5'd1, 1'b0, 13'd2}, 4'hF, 0, 0, 1, "R2 alu");
    issue({2'b11, 5'd3, 6'b000000, 5'd1, 1'b1, 13'd8}, 4'h0, 0, 0, 1, "R2 memory");

    // R3 each condition: own flag only (taken), all others (not taken)
    issue(encBr(4'b0001, 22'd4), 4'b0100, 0, 0, 1, "R3 z taken");
    issue(encBr(4'b0001, 22'd4), 4'b1011, 0, 0, 1, "R3 z not taken");
    issue(encBr(4'b0101, 22'd3), 4'b0001, 0, 0, 1, "R3 c taken");
    issue(encBr(4'b0101, 22'd3), 4'b1110, 0, 0, 1, "R3 c not taken");
    issue(encBr(4'b0110, 22'h3ffffe), 4'b1000, 0, 0, 1, "R3 n taken backward");
    issue(encBr(4'b0110, 22'd5), 4'b0111, 0, 0, 1, "R3 n not taken");
    issue(encBr(4'b0111, 22'd6), 4'b0010, 0, 0, 1, "R3 v taken");
    issue(encBr(4'b0111, 22'd6), 4'b1101, 0, 0, 1, "R3 v not taken");
    issue(encBr(4'b1000, 22'h3ffff0), 4'b0000, 0, 0, 1, "R3 always backward");

    // R4 unlisted codes with every flag set
    issue(encBr(4'b0000, 22'd9), 4'hF, 0, 0, 1, "R4 code 0000");
    issue(encBr(4'b1111, 22'd9), 4'hF, 0, 0, 1, "R4 code 1111");
    issue(encBr(4'b0011, 22'd9), 4'hF, 0, 0, 1, "R4 code 0011");

    // R6 jump-and-link, register and immediate operand
    issue(encJmpl(5'd7, 1'b0, 13'd2), 4'h0, 32'h0000_4000, 32'h0000_0100, 1, "R6 jmpl reg");
    issue(encJmpl(5'd15, 1'b1, 13'h1ff8), 4'h0, 32'h0000_3000, 32'hdead_beef, 1, "R6 jmpl imm neg");

    // R7 jump with destination 0
    issue(encJmpl(5'd0, 1'b1, 13'd0), 4'h0, 32'hffff_fff0, 0, 1, "R7 jmpl rd0");

    // R5 call crossing the top of memory
    issue(encCall(30'd8), 4'h0, 0, 0, 1, "R5 call wrap");
    issue(encCall(30'h0000_0400), 4'h0, 0, 0, 1, "R5 call forward");

    // R9 transfer words held without a step
    issue(encCall(30'd100), 4'hF, 0, 0, 0, "R9 idle call");
    issue(encJmpl(5'd9, 1'b1, 13'd4), 4'hF, 32'h100, 0, 0, "R9 idle jmpl");

    // R8 a branch never requests a link
    issue(encBr(4'b1000, 22'd2), 4'h0, 0, 0, 1, "R8 branch no link");

    @(negedge clk); stepEn = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule